// File: doc/BRIEF.md
# Soft-Start and Output Protection Supervisor

This block brings a multiphase regulator's output up smoothly and then guards it. When both the controller supply and the gate-driver supply are good and the inhibit input is released, it produces a loop reference that rises in equal steps from zero to the programmed target code over a fixed number of switching clocks. Once the ramp is done the reference follows the target code directly. From that point power-good may rise, provided the sensed output is close enough to the target and the voltage-step controller is not in the middle of a transition.

Throughout the ramp and in regulation it compares a digital sample of the sensed output with two limits. The over-voltage limit is a fixed ratio of the final target code, even while the reference is still rising. The under-voltage limit is a fixed ratio of the reference as it currently stands, and it is armed only once that reference has reached a code standing for 0.6 V. An over-voltage fault requests a crowbar: low-side switches on and high-side switches off. An under-voltage fault requests that all switches be off. Both raise the fault output and hold until the controller supply goes away. A loss of either supply, or an asserted inhibit, turns all switches off without a fault, and normal operation always resumes with a fresh ramp from zero.

Top module: `ss_supervisor`

## Requirements
- R1: During the ramp the reference equals floor(target × n / SS_CYCLES), where n runs 0 to SS_CYCLES−1 over the SS_CYCLES clocks after the ramp starts; afterwards it equals the target code. In the off and fault states the reference is 0.
- R2: The ramp starts only while both vccGood and drvGood are 1 and inhibit is 0. If either supply flag falls during the ramp or regulation, the next clock edge sets allOff to 1 with fault 0 and reference 0; the ramp restarts from zero when the supplies return.
- R3: pGood is 0 during the ramp and in every off or fault state; it can be 1 only in regulation after the full ramp.
- R4: In regulation pGood is 1 exactly when |sense − target| × PG_DEN ≤ target × PG_NUM (12 % by default); it follows the sense input without a clock of delay.
- R5: While vidMask is 1, pGood is 0 regardless of the sensed value.
- R6: Under-voltage is armed once the reference reaches UV_ARM_CODE and stays armed until the next restart. Sense is low when sense × UV_DEN < reference × UV_NUM (60 % by default), using the ramping reference during the ramp. Low on UV_PERSIST (default 2) consecutive clock edges trips: fault 1, allOff 1, crowbar 0. A single low edge does not trip.
- R7: In the ramp or in regulation, sense × OV_DEN > target × OV_NUM (130 % by default) at a clock edge trips at that edge: fault 1, crowbar 1, allOff 0, pGood 0.
- R8: A tripped fault stays latched through inhibit and loss of drvGood. Only vccGood at 0 clears it, after which the block waits in the all-off state with fault 0.
- R9: While inhibit is 1 the block is all-off with reference 0 and no protection checks, so any sense value causes no fault. Releasing inhibit starts the ramp again from n = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock; one ramp step per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| vccGood | input | 1 | Controller supply above its turn-on threshold |
| drvGood | input | 1 | Gate-driver supply above its turn-on threshold |
| inhibit | input | 1 | Hold everything off while 1 |
| vidMask | input | 1 | Voltage-step transition in progress; masks power-good |
| targetCode | input | REF_W | Programmed final reference code |
| senseCode | input | REF_W | Digital sample of the sensed output |
| refCode | output | REF_W | Loop reference (soft-start ramp or target) |
| pGood | output | 1 | Power-good |
| fault | output | 1 | Latched protection fault |
| allOff | output | 1 | Command: all switches off |
| crowbar | output | 1 | Command: low sides on, high sides off |

## Verification
The bench builds the block with an 8-bit code width, a 16-clock ramp and an arming code of 60, keeping the default ratios. The short ramp lets every step of the reference be compared with the computed product for several targets, including the cycle where under-voltage arms. The narrow code width lets power-good be swept over all 256 sense values against four targets, and puts the exact codes on both sides of the 60 % and 130 % limits in reach.

// File: rtl/ss_supervisor_pkg.sv
package ss_supervisor_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrRamp;    // hold ramp counter and arming at zero
    logic stepRamp;   // advance ramp counter
    logic useTarget;  // reference follows target directly
    logic protOn;     // protection checks active
  } ssStrobe_t;

  // Flags from datapath to control
  typedef struct packed {
    logic rampLast;
    logic uvTrip;
    logic ovTrip;
    logic inWindow;
  } ssFlag_t;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_RAMP = 3'd1,
    ST_RUN  = 3'd2,
    ST_UVF  = 3'd3,
    ST_OVF  = 3'd4
  } ssState_t;

endpackage

// File: rtl/ss_supervisor_datapath.sv
module ss_supervisor_datapath
  import ss_supervisor_pkg::*;
#(
  parameter int REF_W       = 10,
  parameter int SS_CYCLES   = 2048,
  parameter int UV_ARM_CODE = 384,
  parameter int UV_NUM      = 3,
  parameter int UV_DEN      = 5,
  parameter int OV_NUM      = 13,
  parameter int OV_DEN      = 10,
  parameter int PG_NUM      = 12,
  parameter int PG_DEN      = 100,
  parameter int UV_PERSIST  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ssStrobe_t        strobe,
  input  logic [REF_W-1:0] targetCode,
  input  logic [REF_W-1:0] senseCode,
  output logic [REF_W-1:0] refCode,
  output ssFlag_t          flags
);

  localparam int SS_LOG = $clog2(SS_CYCLES);
  localparam int PROD_W = REF_W + SS_LOG;
  localparam int RAT_W  = REF_W + 8;
  localparam int UVC_W  = (UV_PERSIST > 1) ? $clog2(UV_PERSIST) : 1;

  // Ramp counter
  logic [SS_LOG-1:0] ssCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ssCnt <= '0;
    else if (strobe.clrRamp)  ssCnt <= '0;
    else if (strobe.stepRamp) ssCnt <= ssCnt + 1'b1;
  end

  logic [PROD_W-1:0] rampProd;
  logic [REF_W-1:0]  rampRef;
  assign rampProd = PROD_W'(targetCode) * PROD_W'(ssCnt);
  assign rampRef  = rampProd[PROD_W-1:SS_LOG];

  always_comb begin
    if (strobe.useTarget)   refCode = targetCode;
    else if (strobe.protOn) refCode = rampRef;
    else                    refCode = '0;
  end

  assign flags.rampLast = (ssCnt == SS_LOG'(SS_CYCLES - 1));

  // Ratio comparisons by cross-multiplication
  logic [RAT_W-1:0] senseW, targetW, refW, diffW;
  logic [REF_W-1:0] diff;
  assign diff    = (senseCode >= targetCode) ? (senseCode - targetCode)
                                             : (targetCode - senseCode);
  assign senseW  = RAT_W'(senseCode);
  assign targetW = RAT_W'(targetCode);
  assign refW    = RAT_W'(refCode);
  assign diffW   = RAT_W'(diff);

  logic ovHigh, uvLow;
  assign ovHigh = (senseW * RAT_W'(OV_DEN)) > (targetW * RAT_W'(OV_NUM));
  assign uvLow  = (senseW * RAT_W'(UV_DEN)) < (refW * RAT_W'(UV_NUM));
  assign flags.inWindow = !((diffW * RAT_W'(PG_DEN)) > (targetW * RAT_W'(PG_NUM)));
  assign flags.ovTrip   = strobe.protOn && ovHigh;

  // Under-voltage arming
  logic uvArmed, atArm, uvActive;
  assign atArm = (refCode >= REF_W'(UV_ARM_CODE));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      uvArmed <= 1'b0;
    else if (strobe.clrRamp)        uvArmed <= 1'b0;
    else if (strobe.protOn && atArm) uvArmed <= 1'b1;
  end
  assign uvActive = strobe.protOn && (uvArmed || atArm);

  // Persistence filter
  generate
    if (UV_PERSIST > 1) begin : gUvFilter
      logic [UVC_W-1:0] uvCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        uvCnt <= '0;
        else if (!(uvActive && uvLow))    uvCnt <= '0;
        else if (uvCnt != UVC_W'(UV_PERSIST - 1)) uvCnt <= uvCnt + 1'b1;
      end
      assign flags.uvTrip = uvActive && uvLow && (uvCnt == UVC_W'(UV_PERSIST - 1));
    end else begin : gUvDirect
      assign flags.uvTrip = uvActive && uvLow;
    end
  endgenerate

endmodule

// File: rtl/ss_supervisor_control.sv
module ss_supervisor_control
  import ss_supervisor_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      vccGood,
  input  logic      drvGood,
  input  logic      inhibit,
  input  logic      vidMask,
  input  ssFlag_t   flags,
  output ssStrobe_t strobe,
  output logic      pGood,
  output logic      fault,
  output logic      allOff,
  output logic      crowbar
);

  ssState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  logic runOk;
  assign runOk = drvGood && !inhibit;

  always_comb begin
    stateNext = state;
    if (!vccGood) begin
      stateNext = ST_OFF;
    end else begin
      case (state)
        ST_OFF:  if (runOk) stateNext = ST_RAMP;
        ST_RAMP: begin
          if (!runOk)              stateNext = ST_OFF;
          else if (flags.ovTrip)   stateNext = ST_OVF;
          else if (flags.uvTrip)   stateNext = ST_UVF;
          else if (flags.rampLast) stateNext = ST_RUN;
        end
        ST_RUN: begin
          if (!runOk)              stateNext = ST_OFF;
          else if (flags.ovTrip)   stateNext = ST_OVF;
          else if (flags.uvTrip)   stateNext = ST_UVF;
        end
        ST_UVF:  stateNext = ST_UVF;
        ST_OVF:  stateNext = ST_OVF;
        default: stateNext = ST_OFF;
      endcase
    end
  end

  logic inRamp, inRun;
  assign inRamp = (state == ST_RAMP);
  assign inRun  = (state == ST_RUN);

  assign strobe.clrRamp   = !(inRamp || inRun);
  assign strobe.stepRamp  = inRamp;
  assign strobe.useTarget = inRun;
  assign strobe.protOn    = inRamp || inRun;

  assign pGood   = inRun && flags.inWindow && !vidMask;
  assign fault   = (state == ST_UVF) || (state == ST_OVF);
  assign allOff  = (state == ST_OFF) || (state == ST_UVF);
  assign crowbar = (state == ST_OVF);

endmodule

// File: rtl/ss_supervisor.sv
module ss_supervisor
  import ss_supervisor_pkg::*;
#(
  parameter int REF_W       = 10,
  parameter int SS_CYCLES   = 2048,
  parameter int UV_ARM_CODE = 384,
  parameter int UV_NUM      = 3,
  parameter int UV_DEN      = 5,
  parameter int OV_NUM      = 13,
  parameter int OV_DEN      = 10,
  parameter int PG_NUM      = 12,
  parameter int PG_DEN      = 100,
  parameter int UV_PERSIST  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vccGood,
  input  logic             drvGood,
  input  logic             inhibit,
  input  logic             vidMask,
  input  logic [REF_W-1:0] targetCode,
  input  logic [REF_W-1:0] senseCode,
  output logic [REF_W-1:0] refCode,
  output logic             pGood,
  output logic             fault,
  output logic             allOff,
  output logic             crowbar
);

  ssStrobe_t strobe;
  ssFlag_t   flags;

  ss_supervisor_control uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .vccGood (vccGood),
    .drvGood (drvGood),
    .inhibit (inhibit),
    .vidMask (vidMask),
    .flags   (flags),
    .strobe  (strobe),
    .pGood   (pGood),
    .fault   (fault),
    .allOff  (allOff),
    .crowbar (crowbar)
  );

  ss_supervisor_datapath #(
    .REF_W       (REF_W),
    .SS_CYCLES   (SS_CYCLES),
    .UV_ARM_CODE (UV_ARM_CODE),
    .UV_NUM      (UV_NUM),
    .UV_DEN      (UV_DEN),
    .OV_NUM      (OV_NUM),
    .OV_DEN      (OV_DEN),
    .PG_NUM      (PG_NUM),
    .PG_DEN      (PG_DEN),
    .UV_PERSIST  (UV_PERSIST)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .targetCode (targetCode),
    .senseCode  (senseCode),
    .refCode    (refCode),
    .flags      (flags)
  );

endmodule

// File: rtl/ss_supervisor_checker.sv
module ss_supervisor_checker #(
  parameter int REF_W  = 10,
  parameter int PG_NUM = 12,
  parameter int PG_DEN = 100
) (
  input logic             clk,
  input logic             rstN,
  input logic             vccGood,
  input logic             vidMask,
  input logic [REF_W-1:0] targetCode,
  input logic [REF_W-1:0] senseCode,
  input logic [REF_W-1:0] refCode,
  input logic             pGood,
  input logic             fault,
  input logic             allOff,
  input logic             crowbar
);

  logic [31:0] gap;
  assign gap = (senseCode >= targetCode) ? 32'(senseCode - targetCode)
                                         : 32'(targetCode - senseCode);

  // R1: reference never falls while powered and the target holds
  assert_ref_mono_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!allOff && !crowbar && $past(!allOff) && $stable(targetCode))
      |-> (refCode >= $past(refCode)));

  // R3: power-good only after the ramp has handed over to the target
  assert_pg_after_ramp_R3: assert property (@(posedge clk) disable iff (!rstN)
    pGood |-> (refCode == targetCode) && !fault && !allOff);

  // R4: power-good implies the sense code lies inside the window
  assert_pg_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    pGood |-> (gap * 32'(PG_DEN) <= 32'(targetCode) * 32'(PG_NUM)));

  // R5: transition mask keeps power-good low
  assert_pg_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    vidMask |-> !pGood);

  // R7: crowbar is exclusive with all-off and always flagged
  assert_crowbar_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    crowbar |-> fault && !allOff && !pGood);

  // R8: a fault survives every edge at which the controller supply is good
  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fault && vccGood) |=> fault);

  // R9: switches off means a zero reference
  assert_off_ref_R9: assert property (@(posedge clk) disable iff (!rstN)
    allOff |-> (refCode == '0));

endmodule

bind ss_supervisor ss_supervisor_checker #(
  .REF_W  (REF_W),
  .PG_NUM (PG_NUM),
  .PG_DEN (PG_DEN)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .vccGood    (vccGood),
  .vidMask    (vidMask),
  .targetCode (targetCode),
  .senseCode  (senseCode),
  .refCode    (refCode),
  .pGood      (pGood),
  .fault      (fault),
  .allOff     (allOff),
  .crowbar    (crowbar)
);

// File: tb/ss_supervisor_test.sv
`timescale 1ns/1ps
module ss_supervisor_test;

  localparam int W     = 8;
  localparam int SS    = 16;
  localparam int ARM   = 60;
  localparam real TCLK = 5.0;

  logic         clk = 1'b0;
  logic         rstN;
  logic         vccGood, drvGood, inhibit, vidMask;
  logic [W-1:0] targetCode, senseCode, refCode;
  logic         pGood, fault, allOff, crowbar;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  ss_supervisor #(
    .REF_W       (W),
    .SS_CYCLES   (SS),
    .UV_ARM_CODE (ARM)
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .vccGood    (vccGood),
    .drvGood    (drvGood),
    .inhibit    (inhibit),
    .vidMask    (vidMask),
    .targetCode (targetCode),
    .senseCode  (senseCode),
    .refCode    (refCode),
    .pGood      (pGood),
    .fault      (fault),
    .allOff     (allOff),
    .crowbar    (crowbar)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Ramp from off to regulation; mode 0: sense tracks ref, mode 1: sense at 70 % of ref
  task automatic rampUp(input int t, input int mode);
    targetCode = W'(t);
    vccGood = 1'b1; drvGood = 1'b1; inhibit = 1'b0;
    step();
    for (int n = 0; n < SS; n++) begin
      int e;
      e = (t * n) / SS;
      chk("R1", "ramp ref", int'(refCode), e);
      chk("R3", "pGood in ramp", int'(pGood), 0);
      chk("R2", "allOff in ramp", int'(allOff), 0);
      senseCode = (mode == 0) ? W'(e) : W'((e * 7 + 9) / 10);
      step();
    end
    chk("R1", "ref after ramp", int'(refCode), t);
    chk("R6", "no fault on tracking ramp", int'(fault), 0);
    senseCode = W'(t);
    #1;
    chk("R3", "pGood in regulation", int'(pGood), 1);
  endtask

  task automatic supplyCycle();
    vccGood = 1'b0;
    step();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #(TCLK * 100000);
    nVec++; nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; vccGood = 1'b0; drvGood = 1'b0; inhibit = 1'b0; vidMask = 1'b0;
    targetCode = '0; senseCode = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset ref", int'(refCode), 0);
    chk("R2", "reset allOff", int'(allOff), 1);
    chk("R3", "reset pGood", int'(pGood), 0);
    chk("R8", "reset fault", int'(fault), 0);
    chk("R7", "reset crowbar", int'(crowbar), 0);
    rstN = 1'b1;

    // R2: one supply alone never starts the ramp
    targetCode = 8'd200; vccGood = 1'b1; drvGood = 1'b0;
    repeat (3) begin
      step();
      chk("R2", "no start without driver supply", int'(allOff), 1);
      chk("R2", "ref idle", int'(refCode), 0);
    end
    vccGood = 1'b0; drvGood = 1'b1;
    repeat (2) begin
      step();
      chk("R2", "no start without controller supply", int'(allOff), 1);
    end

    // R1/R6: ramp with sense at 70 % of the ramping reference
    rampUp(200, 1);

    // R4: full sense sweep against several targets
    foreach (sweepT[i]) begin
      int t;
      t = sweepT[i];
      targetCode = W'(t); senseCode = W'(t);
      step();
      for (int v = 0; v < 256; v++) begin
        int d, e;
        senseCode = W'(v);
        #1;
        d = (v >= t) ? v - t : t - v;
        e = (d * 100 > t * 12) ? 0 : 1;
        chk("R4", "pGood window", int'(pGood), e);
        senseCode = W'(t);
        @(negedge clk);
      end
    end

    // R5: mask
    targetCode = 8'd100; senseCode = 8'd100;
    step();
    vidMask = 1'b1; #1;
    chk("R5", "pGood masked", int'(pGood), 0);
    step();
    chk("R5", "pGood masked after edge", int'(pGood), 0);
    vidMask = 1'b0; #1;
    chk("R5", "pGood after mask", int'(pGood), 1);

    // R6: boundary, glitch and trip in regulation (target 100, limit 60)
    senseCode = 8'd60;
    repeat (3) begin
      step();
      chk("R6", "sense at 60 % holds", int'(fault), 0);
    end
    senseCode = 8'd59; step();
    chk("R6", "single low edge", int'(fault), 0);
    senseCode = 8'd100; step();
    chk("R6", "after glitch", int'(fault), 0);
    senseCode = 8'd59; step();
    chk("R6", "first low edge", int'(fault), 0);
    step();
    chk("R6", "uv fault", int'(fault), 1);
    chk("R6", "uv allOff", int'(allOff), 1);
    chk("R6", "uv crowbar", int'(crowbar), 0);
    chk("R3", "pGood in fault", int'(pGood), 0);

    // R8: latch
    drvGood = 1'b0; step();
    chk("R8", "fault kept on driver loss", int'(fault), 1);
    inhibit = 1'b1; step();
    chk("R8", "fault kept on inhibit", int'(fault), 1);
    drvGood = 1'b1; inhibit = 1'b0; senseCode = 8'd100; step();
    chk("R8", "fault kept on restore", int'(fault), 1);
    chk("R8", "still off", int'(allOff), 1);
    supplyCycle();
    chk("R8", "fault cleared by supply", int'(fault), 0);
    chk("R8", "off after clear", int'(allOff), 1);
    rampUp(100, 0);

    // R7: over-voltage boundary in regulation (target 100, limit 130)
    senseCode = 8'd130;
    repeat (3) begin
      step();
      chk("R7", "sense at 130 % holds", int'(fault), 0);
    end
    senseCode = 8'd131; step();
    chk("R7", "ov fault", int'(fault), 1);
    chk("R7", "ov crowbar", int'(crowbar), 1);
    chk("R7", "ov not allOff", int'(allOff), 0);
    chk("R7", "ov pGood", int'(pGood), 0);
    supplyCycle();
    chk("R7", "crowbar released", int'(crowbar), 0);

    // R7: over-voltage uses the final target during the ramp
    targetCode = 8'd100; senseCode = 8'd0; vccGood = 1'b1;
    step(); step(); step();
    chk("R7", "ramp before ov", int'(fault), 0);
    senseCode = 8'd131; step();
    chk("R7", "ov during ramp", int'(crowbar), 1);
    supplyCycle();

    // R6: arming at code 60 during a ramp to 200 with sense 0
    targetCode = 8'd200; senseCode = 8'd0; vccGood = 1'b1;
    step();
    for (int n = 0; n < 5; n++) begin
      step();
      chk("R6", "not armed below code 60", int'(fault), 0);
    end
    step();
    chk("R6", "first armed low edge", int'(fault), 0);
    step();
    chk("R6", "armed trip", int'(fault), 1);
    supplyCycle();

    // R9: inhibit
    rampUp(150, 0);
    inhibit = 1'b1; senseCode = 8'd0; step();
    chk("R9", "inhibit allOff", int'(allOff), 1);
    chk("R9", "inhibit ref", int'(refCode), 0);
    chk("R9", "inhibit pGood", int'(pGood), 0);
    repeat (4) begin
      step();
      chk("R9", "no protection while inhibited", int'(fault), 0);
    end
    senseCode = 8'd255; step();
    chk("R9", "no ov while inhibited", int'(crowbar), 0);
    senseCode = 8'd0;
    rampUp(150, 0);

    // R2: driver supply loss in regulation
    drvGood = 1'b0; step();
    chk("R2", "driver loss allOff", int'(allOff), 1);
    chk("R2", "driver loss ref", int'(refCode), 0);
    chk("R2", "driver loss no fault", int'(fault), 0);
    senseCode = 8'd0;
    rampUp(150, 0);

    finishRun();
  end

  int sweepT [4] = '{200, 100, 50, 13};

endmodule